// File: doc/BRIEF.md
# Single-Bus Microcoded CPU Datapath

This block is the datapath half of a microcoded processor. An external sequencer presents one decoded control word per clock. Every transfer inside the block crosses a single shared 32-bit bus. In any cycle one source may drive that bus: the immediate generator, the register file, the ALU or the memory. Any of four holding registers may capture what the bus carries: the instruction register, the two ALU operands A and B, and the memory address register.

The register file has 33 entries. Entries 0 to 31 are the architectural registers. The program counter is a 33rd entry at a fixed index, so PC updates are ordinary register writes. The datapath reports three things back to the sequencer: the opcode field of the instruction register, a condition flag computed by the ALU, and a busy flag from a small single-port memory model. The sequencer uses the busy flag to spin until a memory access has settled.

The block is driven one cycle at a time. A multi-step macro-instruction is simply a sequence of control words. Examples are an instruction fetch, a register-register operation or a memory-to-memory add.

Top module: `sbus_datapath`

## Requirements
- R1: At most one of `imm_en`, `reg_en`, `alu_en`, `mem_en` is high in any cycle. `bus_o` shows the enabled source, or all zeros when no source is enabled.
- R2: `reg_sel` picks the register file entry: 0 = PC entry (index 32), 1 = rd (IR[11:7]), 2 = rs1 (IR[19:15]), 3 = rs2 (IR[24:20]). With `reg_en` high and `reg_w` low, the entry drives the bus. With `reg_w` high, the bus value is written into the entry at the clock edge. `reg_en` and `reg_w` are never both high.
- R3: Register 0 always reads as zero, and a write to it has no effect.
- R4: `inst_ld`, `a_ld`, `b_ld` and `ma_ld` each capture the bus into IR, A, B and the memory address register at the clock edge, and hold otherwise. Reset clears IR, A, B, the address register and registers 1 to 31, and sets the PC entry to `RESET_PC`.
- R5: With `alu_func` low, `alu_op` selects the ALU function: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed less-than, 6 equal, 7 not-equal, 8 signed greater-or-equal. Comparisons return 1 or 0. Codes 9 to 15 add. `alu_en` drives the result onto the bus.
- R6: With `alu_func` high, the function comes from IR. For opcode 0110011: funct3 (IR[14:12]) 000 gives add, or subtract when IR[30] is set; 010 gives less-than; 100 gives xor; 110 gives or; 111 gives and. Opcode 0010011 decodes the same way except that IR[30] is ignored. For opcode 1100011: funct3 000 gives equal, 001 not-equal, 100 less-than, 101 greater-or-equal. Anything else gives add.
- R7: `imm_sel` picks the immediate: 0 = IR[31:20] sign-extended; 1 = branch form {IR[31],IR[7],IR[30:25],IR[11:8],0} sign-extended; 2 = jump form {IR[31],IR[19:12],IR[20],IR[30:21],0} sign-extended; 3 = the constant 4.
- R8: `opcode_o` equals IR[6:0]. `cond_o` is high exactly when the current ALU result is non-zero.
- R9: The memory word index is bits [AW+1:2] of the address register, where AW = log2(`MEM_WORDS`), so addresses wrap modulo 4·`MEM_WORDS` bytes. `mem_en` drives the addressed word onto the bus. `mem_w` writes the bus into that word at the clock edge.
- R10: `busy_o` is low after reset. A cycle with `ma_ld` or `mem_w` makes `busy_o` high for exactly the next `MEM_LAT` cycles, after which it falls unless a new access starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imm_en | input | 1 | Immediate generator drives bus |
| reg_en | input | 1 | Register file read drives bus |
| alu_en | input | 1 | ALU result drives bus |
| mem_en | input | 1 | Memory read data drives bus |
| inst_ld | input | 1 | Load instruction register from bus |
| a_ld | input | 1 | Load operand A from bus |
| b_ld | input | 1 | Load operand B from bus |
| ma_ld | input | 1 | Load memory address register from bus |
| reg_sel | input | 2 | Register file entry select |
| reg_w | input | 1 | Register file write from bus |
| imm_sel | input | 2 | Immediate format select |
| alu_op | input | 4 | Direct ALU function code |
| alu_func | input | 1 | Take ALU function from IR fields |
| mem_w | input | 1 | Memory write from bus |
| opcode_o | output | 7 | IR[6:0] to the sequencer |
| cond_o | output | 1 | ALU result non-zero |
| busy_o | output | 1 | Memory access in progress |
| bus_o | output | 32 | Current shared bus value |

## Verification
The bench instantiates the block with `MEM_WORDS` = 16, `MEM_LAT` = 2 and `RESET_PC` = 0x100. The small memory lets a byte address of 0x48 alias word 2, so address wrap is exercised with few cycles. The short latency keeps every busy window to two cycles. The non-zero reset PC gives a distinctive first read of the PC entry. All operand and instruction values are built on chip, using only the bus. The bench zeros the PC entry, then doubles it and adds ALU-generated ones bit by bit. Those values are copied into IR and the registers, so every path is reached only through the control word.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int XLEN     = 32;
    localparam int NUM_ARCH = 32;
    localparam int PC_IDX   = NUM_ARCH;
    localparam int NUM_ENT  = NUM_ARCH + 1;
    localparam int ENT_W    = $clog2(NUM_ENT);

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,
        ALU_SUB = 4'd1,
        ALU_AND = 4'd2,
        ALU_OR  = 4'd3,
        ALU_XOR = 4'd4,
        ALU_SLT = 4'd5,
        ALU_EQ  = 4'd6,
        ALU_NE  = 4'd7,
        ALU_SGE = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        RSEL_PC  = 2'd0,
        RSEL_RD  = 2'd1,
        RSEL_RS1 = 2'd2,
        RSEL_RS2 = 2'd3
    } rsel_e;

    typedef enum logic [1:0] {
        IMM_I    = 2'd0,
        IMM_B    = 2'd1,
        IMM_J    = 2'd2,
        IMM_FOUR = 2'd3
    } imm_e;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_REGIMM = 7'b0010011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
endpackage

// File: rtl/sbus_imm_gen.sv
module sbus_imm_gen
    import sbus_pkg::*;
(
    input  logic [31:7]     ir_hi_i,
    input  logic [1:0]      sel_i,
    output logic [XLEN-1:0] imm_o
);
    always_comb begin
        unique case (imm_e'(sel_i))
            IMM_I:    imm_o = {{20{ir_hi_i[31]}}, ir_hi_i[31:20]};
            IMM_B:    imm_o = {{19{ir_hi_i[31]}}, ir_hi_i[31], ir_hi_i[7],
                               ir_hi_i[30:25], ir_hi_i[11:8], 1'b0};
            IMM_J:    imm_o = {{11{ir_hi_i[31]}}, ir_hi_i[31], ir_hi_i[19:12],
                               ir_hi_i[20], ir_hi_i[30:21], 1'b0};
            default:  imm_o = XLEN'(4);
        endcase
    end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [3:0]      op_i,
    input  logic            use_func_i,
    input  logic [6:0]      opc_i,
    input  logic [2:0]      funct3_i,
    input  logic            alt_i,
    output logic [XLEN-1:0] res_o,
    output logic            cond_o
);
    alu_op_e dec_op;
    alu_op_e eff_op;
    logic    lt_s;

    // function-field decode for macro ALU and branch instructions
    always_comb begin
        dec_op = ALU_ADD;
        if (opc_i == OPC_REG || opc_i == OPC_REGIMM) begin
            unique case (funct3_i)
                3'b000:  dec_op = (alt_i && opc_i == OPC_REG) ? ALU_SUB : ALU_ADD;
                3'b010:  dec_op = ALU_SLT;
                3'b100:  dec_op = ALU_XOR;
                3'b110:  dec_op = ALU_OR;
                3'b111:  dec_op = ALU_AND;
                default: dec_op = ALU_ADD;
            endcase
        end else if (opc_i == OPC_BRANCH) begin
            unique case (funct3_i)
                3'b000:  dec_op = ALU_EQ;
                3'b001:  dec_op = ALU_NE;
                3'b100:  dec_op = ALU_SLT;
                3'b101:  dec_op = ALU_SGE;
                default: dec_op = ALU_ADD;
            endcase
        end
    end

    always_comb begin
        eff_op = use_func_i ? dec_op : alu_op_e'(op_i);
        lt_s   = $signed(a_i) < $signed(b_i);
        unique case (eff_op)
            ALU_SUB: res_o = a_i - b_i;
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            ALU_XOR: res_o = a_i ^ b_i;
            ALU_SLT: res_o = XLEN'(lt_s);
            ALU_EQ:  res_o = XLEN'(a_i == b_i);
            ALU_NE:  res_o = XLEN'(a_i != b_i);
            ALU_SGE: res_o = XLEN'(!lt_s);
            default: res_o = a_i + b_i;
        endcase
        cond_o = |res_o;
    end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
    import sbus_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ENT_W-1:0] idx_i,
    input  logic             we_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [XLEN-1:0]  rdata_o
);
    logic [XLEN-1:0] regs_q [NUM_ENT];
    logic [XLEN-1:0] regs_d [NUM_ENT];

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i && idx_i != '0) begin
            regs_d[idx_i] = wdata_i;
        end
        rdata_o = (idx_i == '0) ? '0 : regs_q[idx_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                regs_q[i] <= (i == PC_IDX) ? RESET_PC : '0;
            end
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    // R3: entry zero never yields anything but zero
    p_zero_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_i == '0) |-> (rdata_o == '0));

    // R2: a write to a non-zero entry is read back on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i != '0) |=> ((idx_i != $past(idx_i)) || (rdata_o == $past(wdata_i))));
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem
    import sbus_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int LAT   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(WORDS)-1:0] widx_i,
    input  logic                     start_i,
    input  logic                     we_i,
    input  logic [XLEN-1:0]          wdata_i,
    output logic [XLEN-1:0]          rdata_o,
    output logic                     busy_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } mst_t;

    mst_t            st_d, st_q;
    logic [XLEN-1:0] mem_q [WORDS];
    logic [XLEN-1:0] mem_d [WORDS];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
        if (start_i) begin
            st_d.cnt = CNT_W'(LAT);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        rdata_o = mem_q[widx_i];
        busy_o  = (st_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // R10: an access start raises busy in the following cycle
    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R10: busy drops once the last counted cycle has passed
    p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i && st_q.cnt == CNT_W'(1)) |=> !busy_o);

    // R10: without a start, an idle memory stays idle
    p_busy_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    // R9: a written word is what the same address reads next
    p_write_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((widx_i != $past(widx_i)) || (rdata_o == $past(wdata_i))));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int               MEM_WORDS = 64,
    parameter int               MEM_LAT   = 3,
    parameter logic [XLEN-1:0]  RESET_PC  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imm_en,
    input  logic            reg_en,
    input  logic            alu_en,
    input  logic            mem_en,
    input  logic            inst_ld,
    input  logic            a_ld,
    input  logic            b_ld,
    input  logic            ma_ld,
    input  logic [1:0]      reg_sel,
    input  logic            reg_w,
    input  logic [1:0]      imm_sel,
    input  logic [3:0]      alu_op,
    input  logic            alu_func,
    input  logic            mem_w,
    output logic [6:0]      opcode_o,
    output logic            cond_o,
    output logic            busy_o,
    output logic [XLEN-1:0] bus_o
);
    localparam int MEM_AW = $clog2(MEM_WORDS);

    typedef struct packed {
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] ma;
    } latch_t;

    latch_t           st_d, st_q;
    logic [XLEN-1:0]  imm_val;
    logic [XLEN-1:0]  reg_rdata;
    logic [XLEN-1:0]  alu_res;
    logic [XLEN-1:0]  mem_rdata;
    logic [XLEN-1:0]  bus;
    logic [ENT_W-1:0] reg_idx;
    logic             unused_ma_bits;

    assign unused_ma_bits = ^{st_q.ma[XLEN-1:MEM_AW+2], st_q.ma[1:0]};

    // register file address from the control word and IR fields
    always_comb begin
        unique case (rsel_e'(reg_sel))
            RSEL_PC:  reg_idx = ENT_W'(PC_IDX);
            RSEL_RD:  reg_idx = ENT_W'(st_q.ir[11:7]);
            RSEL_RS1: reg_idx = ENT_W'(st_q.ir[19:15]);
            default:  reg_idx = ENT_W'(st_q.ir[24:20]);
        endcase
    end

    sbus_imm_gen u_imm (
        .ir_hi_i (st_q.ir[31:7]),
        .sel_i   (imm_sel),
        .imm_o   (imm_val)
    );

    sbus_regfile #(.RESET_PC(RESET_PC)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (reg_idx),
        .we_i    (reg_w),
        .wdata_i (bus),
        .rdata_o (reg_rdata)
    );

    sbus_alu u_alu (
        .a_i        (st_q.a),
        .b_i        (st_q.b),
        .op_i       (alu_op),
        .use_func_i (alu_func),
        .opc_i      (st_q.ir[6:0]),
        .funct3_i   (st_q.ir[14:12]),
        .alt_i      (st_q.ir[30]),
        .res_o      (alu_res),
        .cond_o     (cond_o)
    );

    sbus_mem #(.WORDS(MEM_WORDS), .LAT(MEM_LAT)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .widx_i  (st_q.ma[MEM_AW+1:2]),
        .start_i (ma_ld | mem_w),
        .we_i    (mem_w),
        .wdata_i (bus),
        .rdata_o (mem_rdata),
        .busy_o  (busy_o)
    );

    // shared bus: masked OR of the four possible drivers
    always_comb begin
        bus = ({XLEN{imm_en}}           & imm_val)
            | ({XLEN{reg_en & ~reg_w}}  & reg_rdata)
            | ({XLEN{alu_en}}           & alu_res)
            | ({XLEN{mem_en}}           & mem_rdata);
    end

    // next values of the bus-loaded holding registers
    always_comb begin
        st_d = st_q;
        if (inst_ld) st_d.ir = bus;
        if (a_ld)    st_d.a  = bus;
        if (b_ld)    st_d.b  = bus;
        if (ma_ld)   st_d.ma = bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opcode_o = st_q.ir[6:0];
    assign bus_o    = bus;

    // R1: never more than one bus source
    p_single_driver_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({imm_en, reg_en, alu_en, mem_en}) <= 1);

    // R1: an undriven bus carries zero
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(imm_en || reg_en || alu_en || mem_en) |-> (bus_o == '0));

    // R2: read and write of the register file are exclusive
    p_reg_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && reg_w));

    // R4: IR load shows up on the opcode output one cycle later
    p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inst_ld |=> (opcode_o == $past(bus_o[6:0])));

    // R4: operand A holds when not loaded
    p_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !a_ld |=> $stable(st_q.a));
endmodule

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;
    import sbus_pkg::*;

    localparam int          TB_WORDS = 16;
    localparam int          TB_LAT   = 2;
    localparam logic [31:0] TB_PC    = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        imm_en, reg_en, alu_en, mem_en;
    logic        inst_ld, a_ld, b_ld, ma_ld;
    logic [1:0]  reg_sel, imm_sel;
    logic        reg_w, alu_func, mem_w;
    logic [3:0]  alu_op;
    logic [6:0]  opcode_o;
    logic        cond_o, busy_o;
    logic [31:0] bus_o;

    logic [31:0] bus_s;
    logic [6:0]  op_s;
    logic        cond_s, busy_s;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    sbus_datapath #(.MEM_WORDS(TB_WORDS), .MEM_LAT(TB_LAT), .RESET_PC(TB_PC)) i_sbus_datapath (
        .clk(clk), .rst_n(rst_n),
        .imm_en(imm_en), .reg_en(reg_en), .alu_en(alu_en), .mem_en(mem_en),
        .inst_ld(inst_ld), .a_ld(a_ld), .b_ld(b_ld), .ma_ld(ma_ld),
        .reg_sel(reg_sel), .reg_w(reg_w), .imm_sel(imm_sel), .alu_op(alu_op),
        .alu_func(alu_func), .mem_w(mem_w),
        .opcode_o(opcode_o), .cond_o(cond_o), .busy_o(busy_o), .bus_o(bus_o)
    );

    task automatic clear_ctl();
        imm_en = 0; reg_en = 0; alu_en = 0; mem_en = 0;
        inst_ld = 0; a_ld = 0; b_ld = 0; ma_ld = 0;
        reg_sel = 0; reg_w = 0; imm_sel = 0; alu_op = 0; alu_func = 0; mem_w = 0;
    endtask

    // one control-word cycle: sample outputs mid-cycle, then pass the edge
    task automatic tick();
        #1;
        bus_s = bus_o; op_s = opcode_o; cond_s = cond_o; busy_s = busy_o;
        @(posedge clk);
        @(negedge clk);
        clear_ctl();
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_alu(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return {31'b0, $signed(a) < $signed(b)};
            6: return {31'b0, a == b};
            7: return {31'b0, a != b};
            8: return {31'b0, $signed(a) >= $signed(b)};
            default: return a + b;
        endcase
    endfunction

    function automatic logic [31:0] enc_b(input logic [12:0] v);
        return {v[12], v[10:5], 5'd0, 5'd0, 3'd0, v[4:1], v[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:0] v);
        return {v[20], v[10:1], v[11], v[19:12], 5'd0, 7'b1101111};
    endfunction

    // constant builder: PC entry := v, using only bus transfers
    task automatic build_pc(input logic [31:0] v);
        reg_en = 1; reg_sel = 0; a_ld = 1; tick();
        reg_en = 1; reg_sel = 0; b_ld = 1; tick();
        alu_en = 1; alu_op = 1; reg_sel = 0; reg_w = 1; tick();
        for (int i = 31; i >= 0; i--) begin
            reg_en = 1; reg_sel = 0; a_ld = 1; tick();
            reg_en = 1; reg_sel = 0; b_ld = 1; tick();
            alu_en = 1; alu_op = 0; reg_sel = 0; reg_w = 1; tick();
            if (v[i]) begin
                alu_en = 1; alu_op = 6; b_ld = 1; tick();
                reg_en = 1; reg_sel = 0; a_ld = 1; tick();
                alu_en = 1; alu_op = 0; reg_sel = 0; reg_w = 1; tick();
            end
        end
    endtask

    task automatic set_ir(input logic [31:0] w);
        build_pc(w);
        reg_en = 1; reg_sel = 0; inst_ld = 1; tick();
    endtask

    task automatic write_reg(input int k, input logic [31:0] v);
        set_ir(32'(k) << 7);
        build_pc(v);
        reg_en = 1; reg_sel = 0; a_ld = 1; tick();
        reg_en = 1; reg_sel = 3; b_ld = 1; tick();
        alu_en = 1; alu_op = 0; reg_sel = 1; reg_w = 1; tick();
    endtask

    task automatic load_ab();
        reg_en = 1; reg_sel = 2; a_ld = 1; tick();
        reg_en = 1; reg_sel = 3; b_ld = 1; tick();
    endtask

    task automatic t_reset();
        tick();
        check("R1 idle bus zero", bus_s, 32'h0);
        check("R10 busy low after reset", {31'b0, busy_s}, 32'h0);
        check("R8 opcode zero after reset", {25'b0, op_s}, 32'h0);
        reg_en = 1; reg_sel = 0; tick();
        check("R4 PC entry reset value", bus_s, TB_PC);
        reg_en = 1; reg_sel = 2; tick();
        check("R3 x0 reads zero", bus_s, 32'h0);
    endtask

    task automatic t_regs();
        write_reg(5, 32'hDEAD_BEEF);
        write_reg(31, 32'h0F0F_1234);
        write_reg(0, 32'h0000_1111);
        set_ir((32'd31 << 20) | (32'd5 << 15) | (32'd5 << 7));
        reg_en = 1; reg_sel = 2; tick();
        check("R2 rs1 select", bus_s, 32'hDEAD_BEEF);
        reg_en = 1; reg_sel = 3; tick();
        check("R2 rs2 select", bus_s, 32'h0F0F_1234);
        reg_en = 1; reg_sel = 1; tick();
        check("R2 rd select", bus_s, 32'hDEAD_BEEF);
        set_ir(32'h0);
        reg_en = 1; reg_sel = 1; tick();
        check("R3 write to x0 ignored", bus_s, 32'h0);
    endtask

    task automatic t_alu_pair(input logic [31:0] a, input logic [31:0] b);
        write_reg(1, a);
        write_reg(2, b);
        set_ir((32'd2 << 20) | (32'd1 << 15));
        load_ab();
        for (int op = 0; op < 9; op++) begin
            alu_en = 1; alu_op = 4'(op); tick();
            check($sformatf("R5 alu op %0d", op), bus_s, model_alu(op, a, b));
            check($sformatf("R8 cond op %0d", op), {31'b0, cond_s},
                  {31'b0, model_alu(op, a, b) != 0});
        end
        // unrelated bus traffic without loads must leave A and B alone
        imm_en = 1; imm_sel = 3; tick();
        reg_en = 1; reg_sel = 0; tick();
        alu_en = 1; alu_op = 0; tick();
        check("R4 operands held", bus_s, a + b);
    endtask

    task automatic t_func(input logic [31:0] word, input int exp_op, input string tag);
        set_ir(word | (32'd2 << 20) | (32'd1 << 15));
        load_ab();
        alu_en = 1; alu_func = 1; alu_op = 4'd2; tick();
        check({"R6 ", tag}, bus_s, model_alu(exp_op, 32'hFFFF_FF00, 32'h0000_0010));
    endtask

    task automatic t_funcs();
        write_reg(1, 32'hFFFF_FF00);
        write_reg(2, 32'h0000_0010);
        t_func({7'h00, 10'd0, 3'b000, 5'd0, 7'b0110011}, 0, "reg add");
        t_func({7'h20, 10'd0, 3'b000, 5'd0, 7'b0110011}, 1, "reg sub");
        t_func({7'h20, 10'd0, 3'b000, 5'd0, 7'b0010011}, 0, "imm add ignores bit30");
        t_func({7'h00, 10'd0, 3'b100, 5'd0, 7'b0110011}, 4, "xor");
        t_func({7'h00, 10'd0, 3'b110, 5'd0, 7'b0110011}, 3, "or");
        t_func({7'h00, 10'd0, 3'b111, 5'd0, 7'b0110011}, 2, "and");
        t_func({7'h00, 10'd0, 3'b010, 5'd0, 7'b0110011}, 5, "slt");
        t_func({7'h00, 10'd0, 3'b000, 5'd0, 7'b1100011}, 6, "branch eq");
        t_func({7'h00, 10'd0, 3'b001, 5'd0, 7'b1100011}, 7, "branch ne");
        t_func({7'h00, 10'd0, 3'b100, 5'd0, 7'b1100011}, 5, "branch lt");
        t_func({7'h00, 10'd0, 3'b101, 5'd0, 7'b1100011}, 8, "branch ge");
        t_func({7'h00, 10'd0, 3'b000, 5'd0, 7'b0000011}, 0, "other opcode adds");
    endtask

    task automatic t_imm();
        set_ir({12'hFFB, 20'h00013});
        check("R8 opcode follows IR", {25'b0, opcode_o}, 32'h13);
        imm_en = 1; imm_sel = 0; tick();
        check("R7 I-type negative", bus_s, 32'hFFFF_FFFB);
        set_ir({12'h7F5, 20'h00013});
        imm_en = 1; imm_sel = 0; tick();
        check("R7 I-type positive", bus_s, 32'h0000_07F5);
        set_ir(enc_b(13'h100A));
        check("R8 opcode branch", {25'b0, opcode_o}, 32'h63);
        imm_en = 1; imm_sel = 1; tick();
        check("R7 branch negative", bus_s, 32'hFFFF_F00A);
        set_ir(enc_b(13'h07F4));
        imm_en = 1; imm_sel = 1; tick();
        check("R7 branch positive", bus_s, 32'h0000_07F4);
        set_ir(enc_j(21'h1FFFFE));
        imm_en = 1; imm_sel = 2; tick();
        check("R7 jump negative", bus_s, 32'hFFFF_FFFE);
        set_ir(enc_j(21'h0AB5E6));
        imm_en = 1; imm_sel = 2; tick();
        check("R7 jump positive", bus_s, 32'h000A_B5E6);
        imm_en = 1; imm_sel = 3; tick();
        check("R7 constant four", bus_s, 32'h4);
    endtask

    task automatic busy_window(input string tag);
        for (int i = 0; i < TB_LAT; i++) begin
            tick();
            check({"R10 busy high ", tag}, {31'b0, busy_s}, 32'h1);
        end
        tick();
        check({"R10 busy low ", tag}, {31'b0, busy_s}, 32'h0);
    endtask

    task automatic t_mem();
        build_pc(32'h0000_0008);
        reg_en = 1; reg_sel = 0; ma_ld = 1; tick();
        busy_window("after address load");
        build_pc(32'h1357_2468);
        reg_en = 1; reg_sel = 0; mem_w = 1; tick();
        busy_window("after write");
        build_pc(32'h0000_000C);
        reg_en = 1; reg_sel = 0; ma_ld = 1; tick();
        build_pc(32'h2468_ACE0);
        reg_en = 1; reg_sel = 0; mem_w = 1; tick();
        build_pc(32'h0000_0048);
        reg_en = 1; reg_sel = 0; ma_ld = 1; tick();
        busy_window("before aliased read");
        mem_en = 1; a_ld = 1; tick();
        check("R9 aliased address read", bus_s, 32'h1357_2468);
        build_pc(32'h0000_000C);
        reg_en = 1; reg_sel = 0; ma_ld = 1; tick();
        tick(); tick();
        mem_en = 1; tick();
        check("R9 second word kept apart", bus_s, 32'h2468_ACE0);
        build_pc(32'h0000_0010);
        reg_en = 1; reg_sel = 0; ma_ld = 1; tick();
        tick(); tick();
        mem_en = 1; tick();
        check("R9 unwritten word zero", bus_s, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clear_ctl();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_alu_pair(32'h7FFF_FFF0, 32'h0000_0020);
        t_alu_pair(32'hFFFF_FFFE, 32'h0000_0003);
        t_alu_pair(32'h0000_55AA, 32'h0000_55AA);
        t_funcs();
        t_imm();
        t_mem();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule